// File: doc/BRIEF.md
# Banked CPU Address Decoder

This block sits between an 8-bit CPU and the memories and registers of a 64 KB address space. For every read or write it classifies the 16-bit address, decides whether the access may reach its target at all, and drives a one-hot target select, a write enable and the offset inside the target. Writes into the program-ROM half of the map are not memory writes: they are steered to the cartridge mapper's control input. Video RAM and sprite attribute memory are gated by the current video mode. Disabled external RAM and the unusable hole between attribute memory and I/O never select anything.

Work RAM is seen through two 4 KB windows. The lower window always shows bank 0. The upper window shows a bank chosen by a bank register, which is written through one I/O address. A region above work RAM echoes both windows. Read data comes back one cycle after the request, through a small return state machine. It returns the selected target's byte, or all ones when the access reached no target. A debug output reports which work-RAM bank the current address falls in.

The return state machine has three states. RS_IDLE means no read was issued in the previous cycle. RS_TARGET means a read hit a target whose byte is returned now. RS_FLOAT means a read reached nothing and all ones are returned. From any state, a read with a target goes to RS_TARGET, a read without one goes to RS_FLOAT, and a cycle with no read goes to RS_IDLE.

Top module: `banked_addr_decoder`

## Requirements
- R1: While cpu_rd or cpu_wr is high, tgt_sel has at most one bit set. The bit positions are: 0 fixed ROM 0x0000-0x3FFF, 1 switchable ROM 0x4000-0x7FFF, 2 video RAM 0x8000-0x9FFF, 3 external RAM 0xA000-0xBFFF, 4 work RAM 0xC000-0xFDFF, 5 attribute memory 0xFE00-0xFE9F, 6 I/O 0xFF00-0xFF7F, 7 high RAM 0xFF80-0xFFFE, 8 interrupt-enable 0xFFFF. With neither strobe high, tgt_sel is zero.
- R2: A read in 0x0000-0x7FFF selects bit 0 or 1. A write there raises mapper_wr and leaves tgt_sel at zero. mapper_wr is low for every other address.
- R3: Video RAM is selected only while vid_mode is not 3. In mode 3 there is no select and a read returns 0xFF.
- R4: Attribute memory is selected only while vid_mode is 0 or 1. In modes 2 and 3 there is no select and a read returns 0xFF.
- R5: 0xFEA0-0xFEFF never selects a target. A read there returns 0xFF.
- R6: External RAM is selected only while xram_en is high. Otherwise there is no select and a read returns 0xFF.
- R7: After reset the work-RAM bank register holds 1.
- R8: A write to BANK_REG_ADDR (default 0xFF70) loads the low BANK_W bits of cpu_wdata into the bank register. A value of 0 loads 1 instead. Writes to any other address, and any read, leave the bank unchanged.
- R9: For work RAM, local_addr is {bank, addr[11:0]}. The bank is 0 for 0xC000-0xCFFF and its echo 0xE000-0xEFFF. It is the bank register for 0xD000-0xDFFF and its echo 0xF000-0xFDFF.
- R10: local_addr is addr[13:0] for both ROM windows, addr[12:0] for video and external RAM, addr[7:0] for attribute memory, addr[6:0] for I/O and high RAM, and 0 for interrupt-enable. It is zero when nothing is selected.
- R11: One cycle after a read, rdata_vld is high. cpu_rdata is then the byte of tgt_rdata at slice [8*i+7:8*i] of the target i selected by that read, or 0xFF if no target was selected. One cycle after a cycle without a read, rdata_vld is low.
- R12: tgt_we is high exactly when cpu_wr is high and a target is selected.
- R13: dbg_bank equals the bank register when the address is in 0xD000-0xDFFF or 0xF000-0xFDFF, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | DATA_W | Write data, used by the bank register |
| vid_mode | input | 2 | Current video mode 0-3 |
| xram_en | input | 1 | External RAM enabled |
| tgt_rdata | input | 9*DATA_W | Read bytes of the nine targets, target i at slice i |
| tgt_sel | output | 9 | One-hot target select |
| tgt_we | output | 1 | Write enable for the selected target |
| mapper_wr | output | 1 | Write to the cartridge mapper control input |
| local_addr | output | BANK_W+12 | Offset inside the selected target |
| cpu_rdata | output | DATA_W | Returned read data |
| rdata_vld | output | 1 | cpu_rdata carries a read result |
| dbg_bank | output | BANK_W | Work-RAM bank of the current address |

## Verification
On every cycle, assertions check several properties. At most one target is selected. The mode gates on video RAM and attribute memory hold. A mapper write never coincides with a target select. The bank register is never zero, loads exactly what a bank write implies and otherwise holds. Each read is followed by a valid return, with all ones when nothing was hit. Only the bench scenarios show the address map itself: which target each address selects, the offsets, the echo and bank mapping, and that the returned byte is the right target's slice. The bench sweeps the full address space in every video mode, with external RAM toggling, and walks the bank register through zero and out-of-range values.

// File: rtl/adec_pkg.sv
`timescale 1ns/1ps
package adec_pkg;
    localparam int WIN_W   = 12;
    localparam int NUM_TGT = 9;
    localparam int IDX_W   = $clog2(NUM_TGT);

    localparam int T_ROM0 = 0;
    localparam int T_ROMX = 1;
    localparam int T_VRAM = 2;
    localparam int T_XRAM = 3;
    localparam int T_WRAM = 4;
    localparam int T_OAM  = 5;
    localparam int T_IO   = 6;
    localparam int T_HRAM = 7;
    localparam int T_IE   = 8;

    typedef enum logic [3:0] {
        RG_ROM0, RG_ROMX, RG_VRAM, RG_XRAM, RG_WRAM0, RG_WRAMX,
        RG_OAM, RG_HOLE, RG_IO, RG_HRAM, RG_IE
    } region_e;

    typedef enum logic [1:0] {
        RS_IDLE, RS_TARGET, RS_FLOAT
    } rd_state_e;
endpackage

// File: rtl/adec_region_map.sv
`timescale 1ns/1ps
module adec_region_map
    import adec_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);
    always_comb begin
        unique case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: region = RG_ROM0;
            4'h4, 4'h5, 4'h6, 4'h7: region = RG_ROMX;
            4'h8, 4'h9:             region = RG_VRAM;
            4'hA, 4'hB:             region = RG_XRAM;
            4'hC, 4'hE:             region = RG_WRAM0;
            4'hD:                   region = RG_WRAMX;
            default: begin
                if (addr < 16'hFE00)      region = RG_WRAMX;
                else if (addr < 16'hFEA0) region = RG_OAM;
                else if (addr < 16'hFF00) region = RG_HOLE;
                else if (addr < 16'hFF80) region = RG_IO;
                else if (addr != 16'hFFFF) region = RG_HRAM;
                else                      region = RG_IE;
            end
        endcase
    end
endmodule

// File: rtl/adec_wram_bank.sv
`timescale 1ns/1ps
module adec_wram_bank #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] low;
    logic              unused_hi_bits;

    assign low            = wdata[BANK_W-1:0];
    assign unused_hi_bits = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= BANK_W'(1);
        else if (wr_en)
            bank <= (low == '0) ? BANK_W'(1) : low;
    end

    // R7
    bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank != '0);
    // R8
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && low != '0) |=> bank == $past(low));
    // R8
    bank_zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && low == '0) |=> bank == BANK_W'(1));
    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));
endmodule

// File: rtl/adec_rd_return.sv
`timescale 1ns/1ps
module adec_rd_return
    import adec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_start,
    input  logic                      hit,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
    output logic [DATA_W-1:0]         rdata,
    output logic                      rdata_vld
);
    rd_state_e         state, state_nx;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] slice [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_slice
        assign slice[g] = tgt_rdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        if (!rd_start)
            state_nx = RS_IDLE;
        else if (hit)
            state_nx = RS_TARGET;
        else
            state_nx = RS_FLOAT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (rd_start && hit)
                idx_q <= idx;
        end
    end

    always_comb begin
        rdata     = '1;
        rdata_vld = 1'b0;
        unique case (state)
            RS_IDLE:   rdata_vld = 1'b0;
            RS_TARGET: begin
                rdata_vld = 1'b1;
                rdata     = (idx_q < IDX_W'(NUM_TGT)) ? slice[idx_q] : '1;
            end
            RS_FLOAT:  rdata_vld = 1'b1;
            default:   rdata_vld = 1'b0;
        endcase
    end

    // R11
    ret_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> rdata_vld);
    // R11
    ret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> !rdata_vld);
    // R11
    ret_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !hit) |=> rdata == '1);
endmodule

// File: rtl/banked_addr_decoder.sv
`timescale 1ns/1ps
module banked_addr_decoder
    import adec_pkg::*;
#(
    parameter int          DATA_W        = 8,
    parameter int          BANK_W        = 3,
    parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [1:0]                vid_mode,
    input  logic                      xram_en,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
    output logic [NUM_TGT-1:0]        tgt_sel,
    output logic                      tgt_we,
    output logic                      mapper_wr,
    output logic [BANK_W+WIN_W-1:0]   local_addr,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      rdata_vld,
    output logic [BANK_W-1:0]         dbg_bank
);
    localparam int LA_W = BANK_W + WIN_W;

    region_e           region;
    logic [BANK_W-1:0] bank;
    logic              access;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [LA_W-1:0]   la;

    assign access = cpu_rd | cpu_wr;

    adec_region_map u_map (
        .addr   (cpu_addr),
        .region (region)
    );

    adec_wram_bank #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && (cpu_addr == BANK_REG_ADDR)),
        .wdata (cpu_wdata),
        .bank  (bank)
    );

    always_comb begin
        hit = 1'b0;
        idx = '0;
        la  = '0;
        unique case (region)
            RG_ROM0: begin
                hit = cpu_rd;
                idx = IDX_W'(T_ROM0);
                la  = LA_W'(cpu_addr[13:0]);
            end
            RG_ROMX: begin
                hit = cpu_rd;
                idx = IDX_W'(T_ROMX);
                la  = LA_W'(cpu_addr[13:0]);
            end
            RG_VRAM: begin
                hit = access && (vid_mode != 2'd3);
                idx = IDX_W'(T_VRAM);
                la  = LA_W'(cpu_addr[12:0]);
            end
            RG_XRAM: begin
                hit = access && xram_en;
                idx = IDX_W'(T_XRAM);
                la  = LA_W'(cpu_addr[12:0]);
            end
            RG_WRAM0: begin
                hit = access;
                idx = IDX_W'(T_WRAM);
                la  = {{BANK_W{1'b0}}, cpu_addr[WIN_W-1:0]};
            end
            RG_WRAMX: begin
                hit = access;
                idx = IDX_W'(T_WRAM);
                la  = {bank, cpu_addr[WIN_W-1:0]};
            end
            RG_OAM: begin
                hit = access && !vid_mode[1];
                idx = IDX_W'(T_OAM);
                la  = LA_W'(cpu_addr[7:0]);
            end
            RG_HOLE: hit = 1'b0;
            RG_IO: begin
                hit = access;
                idx = IDX_W'(T_IO);
                la  = LA_W'(cpu_addr[6:0]);
            end
            RG_HRAM: begin
                hit = access;
                idx = IDX_W'(T_HRAM);
                la  = LA_W'(cpu_addr[6:0]);
            end
            RG_IE: begin
                hit = access;
                idx = IDX_W'(T_IE);
            end
            default: hit = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign tgt_sel[g] = hit && (idx == IDX_W'(g));
    end

    assign tgt_we     = cpu_wr && hit;
    assign mapper_wr  = cpu_wr && ((region == RG_ROM0) || (region == RG_ROMX));
    assign local_addr = hit ? la : '0;
    assign dbg_bank   = (region == RG_WRAMX) ? bank : '0;

    adec_rd_return #(.DATA_W(DATA_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (cpu_rd),
        .hit       (hit),
        .idx       (idx),
        .tgt_rdata (tgt_rdata),
        .rdata     (cpu_rdata),
        .rdata_vld (rdata_vld)
    );

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));
    // R1
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> tgt_sel == '0);
    // R2
    mapper_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mapper_wr |-> (tgt_sel == '0 && !tgt_we));
    // R3
    vram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_mode == 2'd3) |-> !tgt_sel[T_VRAM]);
    // R4
    oam_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_mode[1] |-> !tgt_sel[T_OAM]);
    // R6
    xram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xram_en |-> !tgt_sel[T_XRAM]);
    // R12
    we_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> !tgt_we);
endmodule

// File: tb/banked_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module banked_addr_decoder_tb_top;
    import adec_pkg::*;

    localparam int DATA_W = 8;
    localparam int BANK_W = 3;
    localparam int LA_W   = BANK_W + WIN_W;
    localparam logic [15:0] BANK_ADDR = 16'hFF70;
    localparam logic [15:0] EDGES [22] = '{
        16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000,
        16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000, 16'hEFFF, 16'hF000,
        16'hFDFF, 16'hFE00, 16'hFE9F, 16'hFEA0, 16'hFEFF, 16'hFF00,
        16'hFF7F, 16'hFF80, 16'hFFFE, 16'hFFFF
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [15:0]               cpu_addr = '0;
    logic                      cpu_rd = 1'b0;
    logic                      cpu_wr = 1'b0;
    logic [DATA_W-1:0]         cpu_wdata = '0;
    logic [1:0]                vid_mode = '0;
    logic                      xram_en = 1'b0;
    logic [NUM_TGT*DATA_W-1:0] tgt_rdata = '0;
    logic [NUM_TGT-1:0]        tgt_sel;
    logic                      tgt_we;
    logic                      mapper_wr;
    logic [LA_W-1:0]           local_addr;
    logic [DATA_W-1:0]         cpu_rdata;
    logic                      rdata_vld;
    logic [BANK_W-1:0]         dbg_bank;

    int checks = 0;
    int errs   = 0;
    int bank_m = 1;

    always #5 clk = ~clk;

    banked_addr_decoder #(.DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_REG_ADDR(BANK_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .vid_mode(vid_mode), .xram_en(xram_en), .tgt_rdata(tgt_rdata),
        .tgt_sel(tgt_sel), .tgt_we(tgt_we), .mapper_wr(mapper_wr), .local_addr(local_addr),
        .cpu_rdata(cpu_rdata), .rdata_vld(rdata_vld), .dbg_bank(dbg_bank)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected target index from the address map, -1 when nothing is selected.
    function automatic int exp_tgt(input logic [15:0] a, input int mode, input bit xen,
                                   input bit rd, input bit wr);
        if (!(rd || wr)) return -1;
        if (a < 16'h4000) return rd ? 0 : -1;
        if (a < 16'h8000) return rd ? 1 : -1;
        if (a < 16'hA000) return (mode != 3) ? 2 : -1;
        if (a < 16'hC000) return xen ? 3 : -1;
        if (a < 16'hFE00) return 4;
        if (a < 16'hFEA0) return (mode < 2) ? 5 : -1;
        if (a < 16'hFF00) return -1;
        if (a < 16'hFF80) return 6;
        if (a < 16'hFFFF) return 7;
        return 8;
    endfunction

    function automatic int exp_dbg(input logic [15:0] a);
        if (a >= 16'hC000 && a < 16'hFE00 && a[12]) return bank_m;
        return 0;
    endfunction

    function automatic int exp_la(input int e, input logic [15:0] a);
        case (e)
            0, 1:    return int'(a[13:0]);
            2, 3:    return int'(a[12:0]);
            4:       return (exp_dbg(a) << 12) + int'(a[11:0]);
            5:       return int'(a[7:0]);
            6, 7:    return int'(a[6:0]);
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [15:0] a);
        if (a < 16'h8000) return "R2";
        if (a < 16'hA000) return "R3";
        if (a < 16'hC000) return "R6";
        if (a < 16'hFE00) return "R9";
        if (a < 16'hFEA0) return "R4";
        if (a < 16'hFF00) return "R5";
        return "R1";
    endfunction

    task automatic rd_probe(input logic [15:0] a);
        int e;
        int exp_b;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        for (int i = 0; i < NUM_TGT; i++)
            tgt_rdata[i*DATA_W +: DATA_W] = 8'(int'(a[7:0]) + i*29 + 1);
        #1;
        e = exp_tgt(a, int'(vid_mode), xram_en, 1'b1, 1'b0);
        chk(tgt_sel == ((e < 0) ? 9'd0 : 9'(1 << e)), req_of(a), "read select",
            int'(tgt_sel), (e < 0) ? 0 : (1 << e));
        if (e >= 0)
            chk(int'(local_addr) == exp_la(e, a), (e == 4) ? "R9" : "R10", "local address",
                int'(local_addr), exp_la(e, a));
        else
            chk(local_addr == '0, "R10", "local address idle", int'(local_addr), 0);
        chk(int'(dbg_bank) == exp_dbg(a), "R13", "debug bank", int'(dbg_bank), exp_dbg(a));
        chk(!mapper_wr && !tgt_we, "R12", "no write strobes on read",
            int'({mapper_wr, tgt_we}), 0);
        exp_b = (e < 0) ? 8'hFF : int'(tgt_rdata[e*DATA_W +: DATA_W]);
        @(negedge clk);
        cpu_rd = 1'b0;
        #1;
        chk(rdata_vld, "R11", "return valid", int'(rdata_vld), 1);
        chk(int'(cpu_rdata) == exp_b, (e < 0) ? req_of(a) : "R11", "return data",
            int'(cpu_rdata), exp_b);
    endtask

    task automatic wr_probe(input logic [15:0] a, input logic [7:0] d);
        int e;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_wdata = d;
        #1;
        e = exp_tgt(a, int'(vid_mode), xram_en, 1'b0, 1'b1);
        chk(tgt_sel == ((e < 0) ? 9'd0 : 9'(1 << e)), req_of(a), "write select",
            int'(tgt_sel), (e < 0) ? 0 : (1 << e));
        chk(tgt_we == (e >= 0), "R12", "write enable", int'(tgt_we), int'(e >= 0));
        chk(mapper_wr == (a < 16'h8000), "R2", "mapper write", int'(mapper_wr),
            int'(a < 16'h8000));
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a == BANK_ADDR) bank_m = (d[2:0] == 3'd0) ? 1 : int'(d[2:0]);
    endtask

    task automatic bank_look(input int exp);
        @(negedge clk);
        cpu_addr = 16'hD000; cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        chk(int'(dbg_bank) == exp, "R8", "bank register value", int'(dbg_bank), exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 16'hD000;
        #1;
        // R7 / R11: reset state
        chk(!rdata_vld, "R11", "valid after reset", int'(rdata_vld), 0);
        chk(int'(dbg_bank) == 1, "R7", "bank after reset", int'(dbg_bank), 1);
        chk(tgt_sel == '0, "R1", "select idle", int'(tgt_sel), 0);
        rd_probe(16'hD456);
        @(negedge clk); #1;
        chk(!rdata_vld, "R11", "valid idle cycle", int'(rdata_vld), 0);

        // R8: bank register loads, zero mapping, unrelated writes and reads
        wr_probe(BANK_ADDR, 8'h00); bank_look(1);
        wr_probe(BANK_ADDR, 8'h05); bank_look(5);
        rd_probe(16'hF9AB);
        wr_probe(BANK_ADDR, 8'hF8); bank_look(1);
        wr_probe(BANK_ADDR, 8'h0F); bank_look(7);
        wr_probe(16'hFF71, 8'h02);  bank_look(7);
        rd_probe(BANK_ADDR);        bank_look(7);
        rd_probe(16'hDABC);
        wr_probe(BANK_ADDR, 8'h13); bank_look(3);

        for (int m = 0; m < 4; m++) begin
            vid_mode = 2'(m);
            wr_probe(BANK_ADDR, 8'(m*9 + 2));
            bank_look(bank_m);
            for (int k = 0; k < 4096; k++) begin
                xram_en = k[5];
                rd_probe({k[11:0], k[3:0]});
            end
            for (int x = 0; x < 2; x++) begin
                xram_en = x[0];
                foreach (EDGES[j]) rd_probe(EDGES[j]);
            end
            for (int k = 0; k < 256; k++) begin
                xram_en = k[0];
                wr_probe({k[7:0], 8'h3C}, 8'(k));
            end
            foreach (EDGES[j]) wr_probe(EDGES[j], 8'h00);
            bank_look(bank_m);
        end
        finish_run();
    end
endmodule